// File: doc/BRIEF.md
# Single-Parity-Check Soft-In Soft-Out Decoder

This block is the outer soft decoder of an iterative receiver whose outer code is the three-bit even-parity code. That code has four codewords, each of even weight: two information bits followed by one parity bit. For each codeword the block takes three a-priori bit log-likelihood ratios (LLRs) and returns three extrinsic LLRs for the next decoding pass. Each extrinsic value comes from closed-form evaluation of the parity constraint over the other two positions. No trellis is run.

When the caller marks a codeword as belonging to the last pass, the block also returns hard decisions on the two information bits. Each decision is the sign of that bit's full a-posteriori LLR, which is the a-priori value plus the extrinsic value, saturated.

LLRs are signed two's-complement values. A positive value favours bit value 0. Codewords arrive on a valid/ready stream at up to one per cycle. A single output register stage carries each result one cycle after it is accepted.

Top module: `spc_siso_dec`

## Requirements
- R1: A codeword accepted on a rising edge (cw_valid and cw_ready both high) is presented on the ex_* outputs with ex_valid high after that same edge, which is a latency of one cycle.
- R2: While ex_valid is high and ex_ready is low, ex_valid stays high, cw_ready is low, and ex_llr0..2, ex_final and info_bits keep their values.
- R3: cw_ready equals (not ex_valid) or ex_ready. With ex_ready held high, one codeword is accepted every cycle. A result that is read out while no new codeword is accepted clears ex_valid.
- R4: With SCALE_EN=0, the magnitude of the extrinsic LLR of position i is the smaller magnitude of the other two input LLRs. An input of -128 counts as magnitude 127.
- R5: The extrinsic LLR of position i is negative exactly when one, and only one, of the other two inputs is negative. A zero input counts as non-negative. A zero magnitude gives an output of 0.
- R6: With SCALE_EN=1 (the default), the extrinsic magnitude is floor(3*m/4), where m is the magnitude from R4.
- R7: The APP LLR of information position p (0 or 1) is the input LLR plus its extrinsic LLR, saturated to [-128, 127]. info_bits[p] is 1 exactly when that APP LLR is negative.
- R8: ex_final repeats cw_final of the same codeword. info_bits is 2'b00 for any codeword whose final flag is clear.
- R9: During reset, ex_valid is low, cw_ready is high, and all ex_* data outputs are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cw_valid | input | 1 | Input codeword valid |
| cw_ready | output | 1 | Block can accept a codeword |
| cw_llr0 | input | LLR_W | A-priori LLR, info position 0 |
| cw_llr1 | input | LLR_W | A-priori LLR, info position 1 |
| cw_llr2 | input | LLR_W | A-priori LLR, parity position |
| cw_final | input | 1 | Codeword belongs to the last pass |
| ex_valid | output | 1 | Result valid |
| ex_ready | input | 1 | Downstream accepts the result |
| ex_llr0 | output | LLR_W | Extrinsic LLR, position 0 |
| ex_llr1 | output | LLR_W | Extrinsic LLR, position 1 |
| ex_llr2 | output | LLR_W | Extrinsic LLR, position 2 |
| ex_final | output | 1 | Final flag of this result |
| info_bits | output | 2 | Hard information decisions (bit p for position p) |

## Verification
The assertions run on every cycle and cover four things:
- The handshake: a result is held under backpressure, an accepted codeword always becomes valid, and an idle read-out drains the output.
- No extrinsic magnitude ever exceeds the magnitude of either input it was built from.
- The extrinsic sign follows the parity of the other two signs.
- The decisions stay zero on non-final passes.

Only the bench's scenarios can show the exact arithmetic. That covers the min rule, the 3/4 scaling, the treatment of -128 and of zero, and the APP saturation at both ends. They also show results flowing back to back at full rate. The bench checks these against a behavioural model on both a scaled and an unscaled instance.

// File: rtl/spc_pkg.sv
package spc_pkg;

  // Largest positive LLR for a given word width.
  function automatic int llr_hi(input int w);
    return (1 <<< (w - 1)) - 1;
  endfunction

  // Most negative LLR for a given word width.
  function automatic int llr_lo(input int w);
    return -(1 <<< (w - 1));
  endfunction

  // Clamp an integer sum into the LLR range.
  function automatic int llr_sat(input int x, input int w);
    int r;
    r = x;
    if (x > llr_hi(w)) r = llr_hi(w);
    if (x < llr_lo(w)) r = llr_lo(w);
    return r;
  endfunction

  // Magnitude; the most negative code maps to the largest positive one.
  function automatic int llr_mag(input int x, input int w);
    int m;
    m = (x < 0) ? -x : x;
    if (m > llr_hi(w)) m = llr_hi(w);
    return m;
  endfunction

  // Multiply by three quarters, rounding toward zero, without a multiplier.
  function automatic int mag_three_quarters(input int m);
    return (m + (m <<< 1)) >>> 2;
  endfunction

endpackage

// File: rtl/spc_ext_unit.sv
module spc_ext_unit #(
  parameter int LLR_W    = 8,
  parameter bit SCALE_EN = 1'b1
) (
  input  logic signed [LLR_W-1:0] llr_a,
  input  logic signed [LLR_W-1:0] llr_b,
  output logic signed [LLR_W-1:0] ext
);
  import spc_pkg::*;

  int  mag_a, mag_b, mag_min, mag_eff;
  logic flip;

  always_comb begin
    mag_a   = llr_mag(int'(llr_a), LLR_W);
    mag_b   = llr_mag(int'(llr_b), LLR_W);
    mag_min = (mag_a < mag_b) ? mag_a : mag_b;
    flip    = llr_a[LLR_W-1] ^ llr_b[LLR_W-1];
  end

  generate
    if (SCALE_EN) begin : g_scaled
      always_comb mag_eff = mag_three_quarters(mag_min);
    end else begin : g_plain
      always_comb mag_eff = mag_min;
    end
  endgenerate

  always_comb ext = LLR_W'(flip ? -mag_eff : mag_eff);

endmodule

// File: rtl/spc_app_unit.sv
module spc_app_unit #(
  parameter int LLR_W = 8
) (
  input  logic signed [LLR_W-1:0] prior,
  input  logic signed [LLR_W-1:0] ext,
  output logic signed [LLR_W-1:0] app,
  output logic                    hard
);
  import spc_pkg::*;

  always_comb begin
    app  = LLR_W'(llr_sat(int'(prior) + int'(ext), LLR_W));
    hard = app[LLR_W-1];
  end

endmodule

// File: rtl/spc_out_stage.sv
module spc_out_stage #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [DW-1:0] in_data,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [DW-1:0] out_data
);
  logic load;

  always_comb begin
    in_ready = !out_valid || out_ready;
    load     = in_valid && in_ready;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (load) begin
      out_valid <= 1'b1;
      out_data  <= in_data;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  // R1: an accepted codeword is always presented next cycle
  a_r1_load_presents: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> out_valid);

  // R2: a stalled result is held unchanged
  a_r2_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  // R3: read out with nothing new arriving drains the stage
  a_r3_drain: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && !in_valid) |=> !out_valid);

endmodule

// File: rtl/spc_siso_dec.sv
module spc_siso_dec #(
  parameter int LLR_W    = 8,
  parameter bit SCALE_EN = 1'b1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cw_valid,
  output logic                    cw_ready,
  input  logic signed [LLR_W-1:0] cw_llr0,
  input  logic signed [LLR_W-1:0] cw_llr1,
  input  logic signed [LLR_W-1:0] cw_llr2,
  input  logic                    cw_final,
  output logic                    ex_valid,
  input  logic                    ex_ready,
  output logic signed [LLR_W-1:0] ex_llr0,
  output logic signed [LLR_W-1:0] ex_llr1,
  output logic signed [LLR_W-1:0] ex_llr2,
  output logic                    ex_final,
  output logic [1:0]              info_bits
);
  import spc_pkg::*;

  localparam int N_BITS = 3;
  localparam int N_INFO = 2;
  localparam int DW     = N_BITS * LLR_W + N_INFO + 1;

  logic signed [LLR_W-1:0] prior [N_BITS];
  logic signed [LLR_W-1:0] ext   [N_BITS];
  logic signed [LLR_W-1:0] app   [N_INFO];
  logic [N_INFO-1:0]       hard;
  logic [N_INFO-1:0]       dec;
  logic [DW-1:0]           pay_in, pay_out;

  always_comb begin
    prior[0] = cw_llr0;
    prior[1] = cw_llr1;
    prior[2] = cw_llr2;
  end

  // One extrinsic unit per position, fed by the other two positions.
  generate
    for (genvar i = 0; i < N_BITS; i++) begin : g_ext
      spc_ext_unit #(.LLR_W(LLR_W), .SCALE_EN(SCALE_EN)) u_ext (
        .llr_a (prior[(i + 1) % N_BITS]),
        .llr_b (prior[(i + 2) % N_BITS]),
        .ext   (ext[i])
      );

      // R4: extrinsic magnitude never exceeds either source magnitude
      a_r4_ext_mag_bound: assert property (@(posedge clk) disable iff (!rst_n)
        cw_valid |-> (llr_mag(int'(ext[i]), LLR_W) <= llr_mag(int'(prior[(i + 1) % N_BITS]), LLR_W)
                   && llr_mag(int'(ext[i]), LLR_W) <= llr_mag(int'(prior[(i + 2) % N_BITS]), LLR_W)));

      // R5: a non-zero extrinsic carries the parity of the other two signs
      a_r5_ext_sign: assert property (@(posedge clk) disable iff (!rst_n)
        (cw_valid && ext[i] != '0) |->
          (ext[i][LLR_W-1] == (prior[(i + 1) % N_BITS][LLR_W-1] ^ prior[(i + 2) % N_BITS][LLR_W-1])));
    end

    for (genvar p = 0; p < N_INFO; p++) begin : g_app
      spc_app_unit #(.LLR_W(LLR_W)) u_app (
        .prior (prior[p]),
        .ext   (ext[p]),
        .app   (app[p]),
        .hard  (hard[p])
      );
    end
  endgenerate

  always_comb begin
    dec    = cw_final ? hard : '0;
    pay_in = {cw_final, dec, ext[2], ext[1], ext[0]};
  end

  spc_out_stage #(.DW(DW)) u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (cw_valid),
    .in_ready  (cw_ready),
    .in_data   (pay_in),
    .out_valid (ex_valid),
    .out_ready (ex_ready),
    .out_data  (pay_out)
  );

  always_comb begin
    ex_llr0   = pay_out[LLR_W-1:0];
    ex_llr1   = pay_out[2*LLR_W-1:LLR_W];
    ex_llr2   = pay_out[3*LLR_W-1:2*LLR_W];
    info_bits = pay_out[3*LLR_W+N_INFO-1:3*LLR_W];
    ex_final  = pay_out[DW-1];
  end

  // R8: decisions stay cleared on any non-final pass
  a_r8_dec_gated: assert property (@(posedge clk) disable iff (!rst_n)
    (ex_valid && !ex_final) |-> (info_bits == '0));

endmodule

// File: tb/spc_siso_dec_tb.sv
`timescale 1ns/100ps
module spc_siso_dec_tb;
  localparam int W = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic cw_valid, cw_final, ex_ready;
  logic signed [W-1:0] l0, l1, l2;

  logic cw_ready, ex_valid, ex_final;
  logic signed [W-1:0] e0, e1, e2;
  logic [1:0] info;
  logic cw_ready_r, ex_valid_r, ex_final_r;
  logic signed [W-1:0] r0, r1, r2;
  logic [1:0] info_r;

  spc_siso_dec #(.LLR_W(W), .SCALE_EN(1'b1)) u_dut (
    .clk(clk), .rst_n(rst_n), .cw_valid(cw_valid), .cw_ready(cw_ready),
    .cw_llr0(l0), .cw_llr1(l1), .cw_llr2(l2), .cw_final(cw_final),
    .ex_valid(ex_valid), .ex_ready(ex_ready), .ex_llr0(e0), .ex_llr1(e1),
    .ex_llr2(e2), .ex_final(ex_final), .info_bits(info));

  spc_siso_dec #(.LLR_W(W), .SCALE_EN(1'b0)) u_dut_raw (
    .clk(clk), .rst_n(rst_n), .cw_valid(cw_valid), .cw_ready(cw_ready_r),
    .cw_llr0(l0), .cw_llr1(l1), .cw_llr2(l2), .cw_final(cw_final),
    .ex_valid(ex_valid_r), .ex_ready(ex_ready), .ex_llr0(r0), .ex_llr1(r1),
    .ex_llr2(r2), .ex_final(ex_final_r), .info_bits(info_r));

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // expected state of the output register
  bit exp_v, exp_fin, exp_hold;
  int exp_s[3];
  int exp_r[3];
  int exp_ds, exp_dr;

  function automatic int m_abs(int x);
    if (x == -128) return 127;
    return (x < 0) ? -x : x;
  endfunction

  function automatic int m_ext(int a, int b, bit scaled);
    int m;
    m = (m_abs(a) < m_abs(b)) ? m_abs(a) : m_abs(b);
    if (scaled) m = (3 * m) / 4;
    return ((a < 0) != (b < 0)) ? -m : m;
  endfunction

  function automatic int m_clamp(int x);
    if (x > 127) return 127;
    if (x < -128) return -128;
    return x;
  endfunction

  task automatic check(bit ok, string tag, string what, int act, int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d (t=%0t)", tag, what, act, expv, $time);
    end
  endtask

  task automatic model_step();
    int in[3];
    bit acc;
    in[0] = int'(l0); in[1] = int'(l1); in[2] = int'(l2);
    acc = cw_valid && (!exp_v || ex_ready);
    exp_hold = exp_v && !ex_ready;
    if (acc) begin
      exp_v = 1; exp_fin = cw_final;
      for (int i = 0; i < 3; i++) begin
        exp_s[i] = m_ext(in[(i+1)%3], in[(i+2)%3], 1'b1);
        exp_r[i] = m_ext(in[(i+1)%3], in[(i+2)%3], 1'b0);
      end
      exp_ds = 0; exp_dr = 0;
      if (cw_final) begin
        for (int p = 0; p < 2; p++) begin
          if (m_clamp(in[p] + exp_s[p]) < 0) exp_ds += (1 << p);
          if (m_clamp(in[p] + exp_r[p]) < 0) exp_dr += (1 << p);
        end
      end
    end else if (ex_ready) begin
      exp_v = 0;
    end
  endtask

  task automatic compare_outputs();
    int as[3];
    int ar[3];
    string dtag;
    as[0] = int'(e0); as[1] = int'(e1); as[2] = int'(e2);
    ar[0] = int'(r0); ar[1] = int'(r1); ar[2] = int'(r2);
    check(ex_valid == exp_v, "R1", "ex_valid", ex_valid, exp_v);
    check(ex_valid_r == exp_v, "R1", "ex_valid (unscaled)", ex_valid_r, exp_v);
    check(cw_ready == (!exp_v || ex_ready), "R3", "cw_ready", cw_ready, (!exp_v || ex_ready));
    if (exp_v) begin
      for (int i = 0; i < 3; i++) begin
        // R2 when held; otherwise R6 (scaled) and R4/R5 (unscaled)
        check(as[i] == exp_s[i], exp_hold ? "R2" : "R6", $sformatf("scaled ext[%0d]", i), as[i], exp_s[i]);
        check(ar[i] == exp_r[i], exp_hold ? "R2" : "R4 R5", $sformatf("unscaled ext[%0d]", i), ar[i], exp_r[i]);
      end
      check(ex_final == exp_fin, "R8", "ex_final", ex_final, exp_fin);
      dtag = exp_fin ? "R7" : "R8";
      check(int'(info) == exp_ds, dtag, "info_bits (scaled)", int'(info), exp_ds);
      check(int'(info_r) == exp_dr, dtag, "info_bits (unscaled)", int'(info_r), exp_dr);
    end
  endtask

  task automatic directed(int idx, output int a, output int b, output int c);
    case (idx)
      0: begin a = 10;   b = 20;   c = 30;   end
      1: begin a = -5;   b = 40;   c = -60;  end
      2: begin a = -128; b = -128; c = -128; end
      3: begin a = 127;  b = 127;  c = 127;  end
      4: begin a = 0;    b = -7;   c = 9;    end
      5: begin a = -1;   b = -1;   c = 1;    end
      6: begin a = 100;  b = -100; c = 3;    end
      7: begin a = -128; b = 127;  c = 0;    end
      8: begin a = 4;    b = -4;   c = -4;   end
      9: begin a = 127;  b = -128; c = 1;    end
      10: begin a = 100; b = 100;  c = 100;  end   // R7 positive saturation
      default: begin a = -100; b = 100; c = -100; end // R7 negative saturation
    endcase
  endtask

  initial begin
    int a, b, c;
    cw_valid = 0; cw_final = 0; ex_ready = 1; l0 = 0; l1 = 0; l2 = 0;
    exp_v = 0; exp_fin = 0; exp_hold = 0; exp_ds = 0; exp_dr = 0;
    for (int i = 0; i < 3; i++) begin exp_s[i] = 0; exp_r[i] = 0; end
    repeat (3) @(negedge clk);
    // R9: reset state
    check(ex_valid == 0, "R9", "ex_valid in reset", ex_valid, 0);
    check(cw_ready == 1, "R9", "cw_ready in reset", cw_ready, 1);
    check(e0 == 0 && e1 == 0 && e2 == 0, "R9", "ex_llr0 in reset", int'(e0), 0);
    check(info == 0, "R9", "info_bits in reset", int'(info), 0);
    rst_n = 1;
    // directed: back-to-back with ex_ready high, final flag alternating
    for (int k = 0; k < 24; k++) begin
      @(negedge clk);
      model_step();
      compare_outputs();
      directed(k % 12, a, b, c);
      cw_valid = 1; ex_ready = 1; cw_final = (k % 2 == 0) || (k >= 12);
      l0 = W'(a); l1 = W'(b); l2 = W'(c);
    end
    // randomized traffic with backpressure and bursts
    for (int k = 0; k < 3000; k++) begin
      @(negedge clk);
      model_step();
      compare_outputs();
      cw_valid = ($urandom_range(0, 3) != 0);
      ex_ready = (k % 200 < 20) ? 1'b0 : ($urandom_range(0, 9) < 7);
      cw_final = $urandom_range(0, 1);
      l0 = ($urandom_range(0, 7) == 0) ? -8'sd128 : W'($urandom_range(0, 255));
      l1 = ($urandom_range(0, 7) == 0) ? 8'sd127 : W'($urandom_range(0, 255));
      l2 = ($urandom_range(0, 9) == 0) ? 8'sd0 : W'($urandom_range(0, 255));
    end
    @(negedge clk);
    model_step();
    compare_outputs();
    cw_valid = 0;
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

endmodule